// File: doc/BRIEF.md
# Power-of-Two Clock Output Divider

This block drives a clock onto an output pin from one input clock that a source multiplexer upstream has already picked. A counter of sixteen divide-by-2 stages gives sixteen power-of-two ratios. A 4-bit select value picks one of them. Two override controls replace the divided tap. The first is a bypass that passes the input clock through unchanged. The second passes an externally generated 1 Hz clock to the pin. All of these controls arrive as plain input pins that some register outside the block drives.

Turning the divider on starts the counter from a known zero phase. Turning it off never cuts a pulse short. If the divided output is high at that moment, the counter keeps running until the high phase ends. The output is then parked low and the counter is held at zero. While the divider runs, a new select value is held back until the full counter wraps, so that no shortened pulse reaches the pin.

Top module: `clkout_divider`

## Requirements
- R1: While `rst_n` is low, `clk_out` is 0 whatever the other inputs are, and the counter is cleared.
- R2: With `div_en` high and no override, a select value N gives a `clk_out` with a period of 2^(N+1) input cycles and a high phase of 2^N cycles. The first rising edge comes 2^N cycles after the clock edge that samples `div_en` high from idle.
- R3: The 4-bit select `div_sel` is binary. 0 gives input/2, and 15 gives input/65536, the highest stage of the 16-bit counter.
- R4: A change of `div_sel` while the divider runs is ignored until the 16-bit counter wraps from all ones to zero. From that wrap on, the new ratio applies.
- R5: When `div_en` falls while the divided output is high, the high phase runs to its full length. The output then goes low and stays low.
- R6: Once parked, the counter is held at zero. A later enable gives its first rising edge 2^N cycles after enable, just as after reset.
- R7: With `byp_en` high, `clk_out` follows `clk_in` and the divided tap is ignored, whether or not the divider is enabled.
- R8: With `hz_en` high, `clk_out` follows `hz_clk`, and this takes priority over both the bypass and the tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; the divider counts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 4 | Tap select N; output is input/2^(N+1) |
| div_en | input | 1 | Divider run request |
| byp_en | input | 1 | Pass the undivided input clock |
| hz_en | input | 1 | Pass the 1 Hz clock (highest priority) |
| hz_clk | input | 1 | Externally supplied 1 Hz clock |
| clk_out | output | 1 | Clock to the output pin |

## Verification
The hardest case to reach is a deferred select change at the top ratio. It needs a full 65536-cycle counter wrap before the new value can take effect. The bench enables the divider at N=15 and moves the select to 1 a few cycles later. It then checks that the output still rises at cycle 32768 and falls at cycle 65536, and that a period of 4 follows directly after the wrap. The glitch-free stop is reached by dropping the enable partway through a measured high phase. The bench then counts the high samples that remain and checks that the next enable starts again from phase zero.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int unsigned DEF_STAGES = 16;

  typedef enum logic [1:0] {
    SRC_TAP = 2'd0,
    SRC_BYP = 2'd1,
    SRC_HZ  = 2'd2
  } out_src_e;
endpackage

// File: rtl/clkout_chain.sv
module clkout_chain #(
  parameter int unsigned STAGES = 16
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              clr,
  output logic [STAGES-1:0] cnt
);
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic q;
    logic carry;
    if (k == 0) begin : g_lsb
      assign carry = inc;
    end else begin : g_upper
      assign carry = inc & (&cnt[k-1:0]);
    end
    always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (clr)    q <= 1'b0;
      else if (carry)  q <= ~q;
    end
    assign cnt[k] = q;
  end

  p_count_step_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
    inc |=> cnt == $past(cnt) + STAGES'(1));
  p_clear_zero_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl #(
  parameter int unsigned STAGES = 16,
  localparam int unsigned SEL_W = $clog2(STAGES)
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              div_en,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic [STAGES-1:0] cnt,
  output logic              inc,
  output logic              clr,
  output logic              tap
);
  logic             run_q;
  logic [SEL_W-1:0] sel_q;
  logic             wrap;

  assign tap  = cnt[sel_q];
  // keep counting while enabled, or while a high phase is still in flight
  assign inc  = div_en | (run_q & tap);
  assign clr  = ~inc;
  assign wrap = inc & (&cnt);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= '0;
    end else begin
      run_q <= inc;
      if (!run_q || wrap) sel_q <= div_sel;
    end
  end

  p_sel_hold_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_q && !wrap) |=> $stable(sel_q));
  p_high_completes_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_q && !div_en && tap) |=> run_q);
  p_stop_low_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    $fell(run_q) |-> !tap);
  p_idle_zero_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
    !run_q |-> cnt == '0);
endmodule

// File: rtl/clkout_mux.sv
module clkout_mux
  import clkout_pkg::*;
(
  input  logic rst_n,
  input  logic clk_in,
  input  logic tap,
  input  logic byp_en,
  input  logic hz_en,
  input  logic hz_clk,
  output logic clk_out
);
  out_src_e src;

  always_comb begin
    if (hz_en)       src = SRC_HZ;
    else if (byp_en) src = SRC_BYP;
    else             src = SRC_TAP;
  end

  always_comb begin
    unique case (src)
      SRC_HZ:  clk_out = hz_clk;
      SRC_BYP: clk_out = clk_in;
      default: clk_out = tap;
    endcase
    if (!rst_n) clk_out = 1'b0;
  end
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
  parameter int unsigned STAGES = clkout_pkg::DEF_STAGES,
  localparam int unsigned SEL_W = $clog2(STAGES)
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             div_en,
  input  logic             byp_en,
  input  logic             hz_en,
  input  logic             hz_clk,
  output logic             clk_out
);
  logic [STAGES-1:0] cnt;
  logic              inc;
  logic              clr;
  logic              tap;

  clkout_chain #(.STAGES(STAGES)) u_chain (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .inc    (inc),
    .clr    (clr),
    .cnt    (cnt)
  );

  clkout_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .div_en  (div_en),
    .div_sel (div_sel),
    .cnt     (cnt),
    .inc     (inc),
    .clr     (clr),
    .tap     (tap)
  );

  clkout_mux u_mux (
    .rst_n   (rst_n),
    .clk_in  (clk_in),
    .tap     (tap),
    .byp_en  (byp_en),
    .hz_en   (hz_en),
    .hz_clk  (hz_clk),
    .clk_out (clk_out)
  );

  p_reset_low_r1: assert property (@(posedge clk_in)
    !rst_n |-> !clk_out);
endmodule

// File: tb/clkout_divider_tb.sv
`timescale 1ns/1ps
module clkout_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_sel = '0;
  logic       div_en = 1'b0;
  logic       byp_en = 1'b0;
  logic       hz_en = 1'b0;
  logic       hz_clk = 1'b0;
  logic       clk_out;

  int tests = 0;
  int fails = 0;
  localparam int LIM = 70000;

  always #2.5 clk = ~clk;

  clkout_divider u_dut (
    .clk_in (clk), .rst_n (rst_n), .div_sel (div_sel), .div_en (div_en),
    .byp_en (byp_en), .hz_en (hz_en), .hz_clk (hz_clk), .clk_out (clk_out)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // negedge samples until clk_out equals lvl
  task automatic count_to(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (clk_out !== lvl && n < LIM);
  endtask

  task automatic stop_div(input int n);
    div_en = 1'b0;
    repeat ((1 << n) + 4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 low in reset", int'(clk_out), 0);
    byp_en = 1'b1;
    @(posedge clk); #1;
    check("R1 low in reset with bypass", int'(clk_out), 0);
    byp_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 low after reset", int'(clk_out), 0);
  endtask

  task automatic t_period(input int n);
    int r, h, l;
    div_sel = 4'(n);
    div_en = 1'b1;
    count_to(1'b1, r);
    check($sformatf("R2 first rise N=%0d", n), r, 1 << n);
    count_to(1'b0, h);
    check($sformatf("R2 high width N=%0d", n), h, 1 << n);
    count_to(1'b1, l);
    check($sformatf("R3 period N=%0d", n), h + l, 1 << (n + 1));
    stop_div(n);
  endtask

  task automatic t_stop;
    int r, k, lows;
    div_sel = 4'd3;
    div_en = 1'b1;
    count_to(1'b1, r);
    repeat (3) @(negedge clk);
    div_en = 1'b0;
    count_to(1'b0, k);
    check("R5 high phase completes", k, (1 << 3) - 3);
    lows = 0;
    repeat (40) begin
      @(negedge clk);
      if (clk_out === 1'b0) lows++;
    end
    check("R5 parked low", lows, 40);
    div_en = 1'b1;
    count_to(1'b1, r);
    check("R6 re-enable phase", r, 1 << 3);
    stop_div(3);
  endtask

  task automatic t_deferred_sel;
    int r, f, h;
    div_sel = 4'd15;
    div_en = 1'b1;
    repeat (10) @(negedge clk);
    div_sel = 4'd1;
    count_to(1'b1, r);
    check("R4 held select rise", r + 10, 32768);
    count_to(1'b0, f);
    check("R3 N=15 fall at wrap", r + f + 10, 65536);
    count_to(1'b1, r);
    check("R4 new select after wrap", r, 2);
    count_to(1'b0, h);
    check("R4 new high width", h, 2);
    stop_div(1);
  endtask

  task automatic t_bypass;
    int lo, hi;
    div_sel = 4'd2;
    div_en = 1'b1;
    byp_en = 1'b1;
    lo = 0; hi = 0;
    repeat (8) begin
      @(negedge clk); #0.5;
      if (clk_out === 1'b0) lo++;
      @(posedge clk); #1;
      if (clk_out === 1'b1) hi++;
    end
    check("R7 bypass low half over tap", lo, 8);
    check("R7 bypass high half", hi, 8);
    byp_en = 1'b0;
    stop_div(2);
    byp_en = 1'b1;
    @(posedge clk); #1;
    check("R7 bypass while disabled", int'(clk_out), 1);
    byp_en = 1'b0;
  endtask

  task automatic t_override;
    byp_en = 1'b1;
    hz_en = 1'b1;
    @(negedge clk);
    hz_clk = 1'b0;
    @(posedge clk); #1;
    check("R8 override beats bypass", int'(clk_out), 0);
    @(negedge clk);
    hz_clk = 1'b1;
    #0.5;
    check("R8 override follows hz high", int'(clk_out), 1);
    hz_clk = 1'b0;
    #0.5;
    check("R8 override follows hz low", int'(clk_out), 0);
    hz_en = 1'b0;
    byp_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_period(0);
    t_period(4);
    t_period(7);
    t_stop();
    t_bypass();
    t_override();
    t_deferred_sel();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule